// File: doc/BRIEF.md
# Two-Dimensional Eye-Scan Sweep Sequencer

The sequencer walks a receiver's auxiliary sampler across a square grid of sampling points: every combination of a clock-phase code and a decision-threshold code. For each code it drives both the binary value and a thermometer-decoded form, which the phase rotator and the current-steered threshold DAC consume directly. After any code change the sequencer holds the sampler window closed for a programmable number of settling cycles. It then opens the window and counts how many comparator decisions are `1` over a fixed number of valid comparator strobes.

When a grid point finishes, its count is written through a single-cycle write port into an external result memory addressed by phase and threshold. The threshold code is the fast-moving index and sweeps from its lowest to its highest level. The phase code moves only after a full threshold sweep. A one-cycle completion pulse follows the final write, so downstream eye-estimation logic can start only once the whole profile is stored. With the default parameters the grid is 32 by 32 and each point takes 2048 samples into an 11-bit tally.

Top module: `eyescan_sweep_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, phase_code, amp_code, phase_therm and amp_therm are all zero, and sampling, wr_en and done are low.
- R2: A start pulse seen while the sequencer is idle begins a sweep at phase 0, threshold 0. A start pulse during a sweep is ignored: the write sequence, the data and the single completion pulse are unchanged.
- R3: Each grid point's count is the number of strobes with cmp_valid=1 and cmp_bit=1 among exactly 2^CNT_W valid strobes taken while sampling is high. The count saturates at 2^CNT_W-1 and never wraps.
- R4: Comparator strobes that arrive while sampling is low, and cycles with cmp_valid=0, do not alter any count.
- R5: After a sweep starts and after every write, sampling stays low for exactly settle_len cycles (not counting the write cycle) before it rises. With settle_len=0 it rises in the cycle right after the start is accepted or right after the write.
- R6: Points are written with the threshold code as the inner index (0 up to its maximum) and the phase code as the outer index. wr_addr is {phase, threshold}, with phase in the upper PH_W bits.
- R7: Every grid point produces exactly one write, with wr_en high for one cycle. During that cycle, phase_code and amp_code equal the two fields of wr_addr.
- R8: Each thermometer output has bit i set exactly when i is less than its code, so code 0 gives all zeros and the top bit is never set.
- R9: done is high for exactly one cycle, the cycle right after the write of the last point (all-ones address). After that, no writes occur until the next start, and both codes read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (accepted only when idle) |
| settle_len | input | SETTLE_W | Settling cycles after each code change (typically 16) |
| cmp_valid | input | 1 | Comparator strobe: cmp_bit is a fresh decision |
| cmp_bit | input | 1 | Comparator decision |
| phase_code | output | PH_W | Binary clock-phase code |
| amp_code | output | AMP_W | Binary threshold code |
| phase_therm | output | 2^PH_W | Thermometer form of phase_code |
| amp_therm | output | 2^AMP_W | Thermometer form of amp_code |
| sampling | output | 1 | Sampling window open for the current point |
| wr_en | output | 1 | Result memory write strobe |
| wr_addr | output | PH_W+AMP_W | Result address {phase, threshold} |
| wr_data | output | CNT_W | Ones count of the point |
| done | output | 1 | One-cycle sweep-complete pulse |

## Verification
The bench feeds points where every valid decision is `1`, which forces saturation; a counter that wraps would store zero there instead of the maximum. It also sends exactly 2^CNT_W-1 ones mixed with invalid strobes, and keeps asserting strobes during settling and write cycles, so a design that counts outside its window or ignores cmp_valid would report inflated counts. The settle window is measured at settle_len of 16, 3 and 0: an off-by-one timer, or one that stalls at zero, shows up as a wrong gap. A start pulse injected mid-sweep would restart the grid or duplicate the completion pulse in a design that does not gate start by state.

// File: rtl/eyescan_pkg.sv
package eyescan_pkg;

    localparam int DEF_PH_W     = 5;
    localparam int DEF_AMP_W    = 5;
    localparam int DEF_CNT_W    = 11;
    localparam int DEF_SETTLE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SAMPLE,
        ST_WRITE,
        ST_DONE
    } sweep_state_e;

    typedef struct packed {
        logic restart;
        logic advance;
    } grid_ctl_t;

    typedef struct packed {
        logic load;
        logic run;
    } settle_ctl_t;

    typedef struct packed {
        logic clear;
        logic take;
        logic bit_in;
    } tally_ctl_t;

endpackage

// File: rtl/eyescan_therm_dec.sv
module eyescan_therm_dec #(
    parameter int CODE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CODE_W-1:0]        code,
    output logic [(1<<CODE_W)-1:0]   therm
);
    localparam int LEVELS = 1 << CODE_W;

    generate
        for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
            assign therm[i] = (i < int'(code));
        end
    endgenerate

    // R8: number of set bits equals the code value
    p_therm_weight_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(therm) == int'(code));

    // R8: the top level is never lit
    p_therm_top_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !therm[LEVELS-1]);

endmodule

// File: rtl/eyescan_settle_timer.sv
module eyescan_settle_timer
    import eyescan_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  settle_ctl_t         ctl,
    input  logic [SETTLE_W-1:0] len,
    output logic                last
);
    logic [SETTLE_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (ctl.load) begin
            remain <= len;
        end else if (ctl.run && remain != '0) begin
            remain <= remain - SETTLE_W'(1);
        end
    end

    assign last = (remain <= SETTLE_W'(1));

    // R5: while running, the count only moves downward
    p_settle_down_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl.run && !ctl.load && remain > SETTLE_W'(1)) |=> (remain < $past(remain)));

endmodule

// File: rtl/eyescan_ones_counter.sv
module eyescan_ones_counter
    import eyescan_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  tally_ctl_t       ctl,
    output logic [CNT_W-1:0] ones,
    output logic             last_take
);
    localparam logic [CNT_W-1:0] FULL = '1;

    logic [CNT_W-1:0] taken;

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            ones  <= '0;
            taken <= '0;
        end else if (ctl.take) begin
            taken <= taken + CNT_W'(1);
            if (ctl.bit_in && ones != FULL) begin
                ones <= ones + CNT_W'(1);
            end
        end
    end

    assign last_take = ctl.take && (taken == FULL);

    // R3: a full tally stays full until cleared
    p_hold_full_r3: assert property (@(posedge clk) disable iff (rst)
        (ones == FULL && !ctl.clear) |=> (ones == FULL));

    // R3: without a clear the tally never decreases (no wrap)
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        !ctl.clear |=> (ones >= $past(ones)));

    // R4: no strobe taken, no change
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!ctl.take && !ctl.clear) |=> $stable(ones));

endmodule

// File: rtl/eyescan_grid_stepper.sv
module eyescan_grid_stepper
    import eyescan_pkg::*;
#(
    parameter int PH_W  = 5,
    parameter int AMP_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  grid_ctl_t        ctl,
    output logic [PH_W-1:0]  phase,
    output logic [AMP_W-1:0] amp,
    output logic             last_point
);
    localparam logic [PH_W-1:0]  PH_MAX  = '1;
    localparam logic [AMP_W-1:0] AMP_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || ctl.restart) begin
            phase <= '0;
            amp   <= '0;
        end else if (ctl.advance) begin
            if (amp == AMP_MAX) begin
                amp   <= '0;
                phase <= phase + PH_W'(1);
            end else begin
                amp <= amp + AMP_W'(1);
            end
        end
    end

    assign last_point = (amp == AMP_MAX) && (phase == PH_MAX);

    // R6: threshold is the inner index
    p_amp_inner_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl.advance && !ctl.restart && amp != AMP_MAX)
        |=> (amp == AMP_W'($past(amp) + AMP_W'(1))) && $stable(phase));

    // R6: phase moves only when the threshold sweep wraps
    p_phase_outer_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl.advance && !ctl.restart && amp == AMP_MAX)
        |=> (amp == '0) && (phase == PH_W'($past(phase) + PH_W'(1))));

endmodule

// File: rtl/eyescan_sweep_seq.sv
module eyescan_sweep_seq
    import eyescan_pkg::*;
#(
    parameter int PH_W     = DEF_PH_W,
    parameter int AMP_W    = DEF_AMP_W,
    parameter int CNT_W    = DEF_CNT_W,
    parameter int SETTLE_W = DEF_SETTLE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [SETTLE_W-1:0]     settle_len,
    input  logic                    cmp_valid,
    input  logic                    cmp_bit,
    output logic [PH_W-1:0]         phase_code,
    output logic [AMP_W-1:0]        amp_code,
    output logic [(1<<PH_W)-1:0]    phase_therm,
    output logic [(1<<AMP_W)-1:0]   amp_therm,
    output logic                    sampling,
    output logic                    wr_en,
    output logic [PH_W+AMP_W-1:0]   wr_addr,
    output logic [CNT_W-1:0]        wr_data,
    output logic                    done
);
    localparam int ADDR_W = PH_W + AMP_W;

    sweep_state_e state, state_nx;
    grid_ctl_t    grid_ctl;
    settle_ctl_t  settle_ctl;
    tally_ctl_t   tally_ctl;

    logic             go;
    logic             no_settle;
    logic             settle_last;
    logic             last_take;
    logic             last_point;
    logic [CNT_W-1:0] ones;

    assign go        = (state == ST_IDLE) && start;
    assign no_settle = (settle_len == '0);

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (start) state_nx = no_settle ? ST_SAMPLE : ST_SETTLE;
            ST_SETTLE: if (settle_last) state_nx = ST_SAMPLE;
            ST_SAMPLE: if (last_take) state_nx = ST_WRITE;
            ST_WRITE: begin
                if (last_point)     state_nx = ST_DONE;
                else if (no_settle) state_nx = ST_SAMPLE;
                else                state_nx = ST_SETTLE;
            end
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        grid_ctl.restart = go || (state == ST_DONE);
        grid_ctl.advance = (state == ST_WRITE);
        settle_ctl.load  = go || ((state == ST_WRITE) && !last_point);
        settle_ctl.run   = (state == ST_SETTLE);
        tally_ctl.clear  = go || (state == ST_WRITE);
        tally_ctl.take   = (state == ST_SAMPLE) && cmp_valid;
        tally_ctl.bit_in = cmp_bit;
    end

    eyescan_grid_stepper #(.PH_W(PH_W), .AMP_W(AMP_W)) u_grid (
        .clk        (clk),
        .rst        (rst),
        .ctl        (grid_ctl),
        .phase      (phase_code),
        .amp        (amp_code),
        .last_point (last_point)
    );

    eyescan_settle_timer #(.SETTLE_W(SETTLE_W)) u_settle (
        .clk  (clk),
        .rst  (rst),
        .ctl  (settle_ctl),
        .len  (settle_len),
        .last (settle_last)
    );

    eyescan_ones_counter #(.CNT_W(CNT_W)) u_tally (
        .clk       (clk),
        .rst       (rst),
        .ctl       (tally_ctl),
        .ones      (ones),
        .last_take (last_take)
    );

    eyescan_therm_dec #(.CODE_W(PH_W)) u_ph_therm (
        .clk   (clk),
        .rst   (rst),
        .code  (phase_code),
        .therm (phase_therm)
    );

    eyescan_therm_dec #(.CODE_W(AMP_W)) u_amp_therm (
        .clk   (clk),
        .rst   (rst),
        .code  (amp_code),
        .therm (amp_therm)
    );

    assign sampling = (state == ST_SAMPLE);
    assign wr_en    = (state == ST_WRITE);
    assign wr_addr  = {phase_code, amp_code};
    assign wr_data  = ones;
    assign done     = (state == ST_DONE);

    // R7: each write strobe lasts one cycle
    p_write_single_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R9: completion pulse lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: completion directly follows the write of the last point
    p_done_after_last_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(wr_en) && $past(wr_addr) == {ADDR_W{1'b1}}));

    // R2: a start during a sweep does not pull the codes back to the origin
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (start && state == ST_SAMPLE) |=> $stable(wr_addr));

endmodule

// File: tb/eyescan_sweep_seq_bench.sv
module eyescan_sweep_seq_bench;
    localparam int PH_W     = 2;
    localparam int AMP_W    = 2;
    localparam int CNT_W    = 3;
    localparam int SETTLE_W = 8;
    localparam int ADDR_W   = PH_W + AMP_W;
    localparam int NPTS     = 1 << ADDR_W;
    localparam int SAMPLES  = 1 << CNT_W;
    localparam int FULL     = SAMPLES - 1;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  start = 1'b0;
    logic [SETTLE_W-1:0]   settle_len = 8'd16;
    logic                  cmp_valid = 1'b0;
    logic                  cmp_bit = 1'b0;
    logic [PH_W-1:0]       phase_code;
    logic [AMP_W-1:0]      amp_code;
    logic [(1<<PH_W)-1:0]  phase_therm;
    logic [(1<<AMP_W)-1:0] amp_therm;
    logic                  sampling;
    logic                  wr_en;
    logic [ADDR_W-1:0]     wr_addr;
    logic [CNT_W-1:0]      wr_data;
    logic                  done;

    eyescan_sweep_seq #(.PH_W(PH_W), .AMP_W(AMP_W), .CNT_W(CNT_W), .SETTLE_W(SETTLE_W))
    u_eyescan_sweep_seq (
        .clk(clk), .rst(rst), .start(start), .settle_len(settle_len),
        .cmp_valid(cmp_valid), .cmp_bit(cmp_bit),
        .phase_code(phase_code), .amp_code(amp_code),
        .phase_therm(phase_therm), .amp_therm(amp_therm),
        .sampling(sampling), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int therm_of(input int code, input int levels);
        int v = 0;
        for (int i = 0; i < levels; i++) if (i < code) v |= (1 << i);
        return v;
    endfunction

    logic [ADDR_W+CNT_W-1:0] exp_q[$];

    // Monitor state
    logic acc_start = 1'b0;
    bit   mon_run = 0;
    bit   prev_samp = 0;
    bit   prev_wr = 0;
    int   prev_addr = 0;
    int   gap = 0;
    int   done_cnt = 0;
    bit   prev_done = 0;

    always @(posedge clk) acc_start <= start && !mon_run && !rst;

    always @(negedge clk) begin
        if (!rst) begin
            if (acc_start) begin
                mon_run = 1;
                gap = 0;
            end
            if (sampling && !prev_samp && mon_run)
                chk(gap == int'(settle_len), "R5 settle gap", gap, int'(settle_len));
            if (!sampling && !wr_en && mon_run) gap++;
            if (wr_en) begin
                gap = 0;
                if (!mon_run) begin
                    chk(0, "R9 write while idle", int'(wr_addr), -1);
                end else if (exp_q.size() == 0) begin
                    chk(0, "R7 unexpected write", int'(wr_addr), -1);
                end else begin
                    logic [ADDR_W+CNT_W-1:0] e;
                    e = exp_q.pop_front();
                    chk(wr_addr == e[ADDR_W+CNT_W-1:CNT_W], "R6 write address",
                        int'(wr_addr), int'(e[ADDR_W+CNT_W-1:CNT_W]));
                    chk(wr_data == e[CNT_W-1:0], "R3/R4 ones count",
                        int'(wr_data), int'(e[CNT_W-1:0]));
                    chk({phase_code, amp_code} == wr_addr, "R7 codes match address",
                        int'({phase_code, amp_code}), int'(wr_addr));
                    chk(int'(phase_therm) == therm_of(int'(phase_code), 1 << PH_W),
                        "R8 phase thermometer", int'(phase_therm),
                        therm_of(int'(phase_code), 1 << PH_W));
                    chk(int'(amp_therm) == therm_of(int'(amp_code), 1 << AMP_W),
                        "R8 amp thermometer", int'(amp_therm),
                        therm_of(int'(amp_code), 1 << AMP_W));
                end
            end
            if (done) begin
                done_cnt++;
                chk(prev_wr && prev_addr == NPTS - 1, "R9 done after last write",
                    prev_addr, NPTS - 1);
                chk(exp_q.size() == 0, "R9 all points written", exp_q.size(), 0);
                mon_run = 0;
            end
            if (prev_done)
                chk(!done, "R9 done one cycle", int'(done), 0);
            prev_done = done;
            prev_samp = sampling;
            prev_wr   = wr_en;
            prev_addr = int'(wr_addr);
        end
    end

    task automatic run_sweep(input int settle, input int run_id, input bit inject);
        bit injected = 0;
        settle_len = SETTLE_W'(settle);
        done_cnt = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int p = 0; p < NPTS; p++) begin
            int k;
            int ones;
            int cyc;
            int pat;
            k = 0; ones = 0; cyc = 0;
            pat = (p + run_id) % 4;
            // first pass of the loop body reuses the current negedge
            if (p != 0 || settle != 0) @(negedge clk);
            while (k < SAMPLES) begin
                start = 1'b0;
                if (sampling) begin
                    bit v;
                    bit b;
                    case (pat)
                        0: begin v = 1; b = 1; end          // saturation
                        1: begin v = 1; b = 0; end          // all zeros
                        2: begin v = 1; b = k[0]; end       // alternating
                        default: begin
                            v = (cyc % 2 == 0);
                            b = v ? (k < FULL) : 1'b1;      // max without saturating
                        end
                    endcase
                    cyc++;
                    cmp_valid = v;
                    cmp_bit   = b;
                    if (v) begin
                        ones += int'(b);
                        k++;
                    end
                end else begin
                    cmp_valid = 1'b1;
                    cmp_bit   = 1'b1;
                    if (inject && p == 5 && !injected) begin
                        start = 1'b1;
                        injected = 1;
                    end
                end
                if (k < SAMPLES) @(negedge clk);
            end
            exp_q.push_back({ADDR_W'(p), CNT_W'((ones > FULL) ? FULL : ones)});
        end
        while (mon_run || done) begin
            @(negedge clk);
            cmp_valid = 1'b1;
            cmp_bit   = 1'b1;
        end
        repeat (6) @(negedge clk);
        chk(done_cnt == 1, "R2/R9 single completion", done_cnt, 1);
        chk(phase_code == '0 && amp_code == '0, "R9 codes zero after sweep",
            int'({phase_code, amp_code}), 0);
        chk(!sampling, "R9 idle after sweep", int'(sampling), 0);
        cmp_valid = 1'b0;
        cmp_bit   = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(phase_code == '0 && amp_code == '0, "R1 codes in reset",
            int'({phase_code, amp_code}), 0);
        chk(phase_therm == '0 && amp_therm == '0, "R1 thermometers in reset",
            int'({phase_therm, amp_therm}), 0);
        chk(!sampling && !wr_en && !done, "R1 strobes in reset",
            int'({sampling, wr_en, done}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!sampling && !wr_en && !done && phase_code == '0 && amp_code == '0,
            "R1 state after reset", int'({sampling, wr_en, done}), 0);
        run_sweep(16, 0, 0);
        run_sweep(0, 1, 0);
        run_sweep(3, 2, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule